// File: doc/BRIEF.md
# Signed Power-of-Two Divider Using Shifts

This block divides a 32-bit two's-complement dividend by 2^k, where k is a small unsigned shift count, and returns the signed quotient. It uses only shifting, negation and addition. No divide operator is instantiated anywhere. The quotient is truncated toward zero, matching C signed division. A plain arithmetic right shift would instead round negative results toward minus infinity, and this block does not do that.

A build parameter selects one of two datapaths:

- **Magnitude form:** take the absolute value, shift it, then restore the sign.
- **Bias form:** add a rounding bias to negative dividends, then shift arithmetically.

Both forms give bit-identical results. A second parameter chooses between a purely combinational result and one output register stage. The register stage adds one cycle of latency and carries a valid flag. A shift count of 31 or more is outside the legal range. For such a count the block raises an error flag and forces the quotient to zero.

Top module: `pow2_sdiv`

## Requirements
- R1: For a legal shift count k (0 to 30) and a dividend with bit 31 clear, `quotient` equals the dividend logically shifted right by k.
- R2: For a legal k and a dividend with bit 31 set, `quotient` equals the negation of (the negated dividend shifted right by k), which truncates toward zero. For example, -7 with k=2 gives -1, and -8 with k=2 gives -2.
- R3: For dividend 32'h8000_0000 and a legal k, `quotient` equals -(2^(31-k)). So k=0 gives 32'h8000_0000 and k=30 gives 32'hFFFF_FFFE.
- R4: A shift count of 31 or more sets `shamt_err` to 1 and forces `quotient` to 0.
- R5: A legal shift count (0 to 30) keeps `shamt_err` at 0.
- R6: With `REG_OUT`=1, `out_valid` follows `in_valid` one clock later, and `quotient` and `shamt_err` belong to the inputs of that earlier cycle. With `REG_OUT`=0, `out_valid` equals `in_valid` and the results follow the inputs in the same cycle.
- R7: With `REG_OUT`=1, a synchronous active-high `rst` clears `out_valid`, `quotient` and `shamt_err` to 0.
- R8: Both forms give identical results for every dividend and shift count: `FORM`=FORM_MAG (magnitude form, encoding 0) and `FORM`=FORM_BIAS (bias form, encoding 1).
- R9: A shift count of 0 returns the dividend unchanged.
- R10: With `REG_OUT`=1, a cycle with `in_valid` low leaves `quotient` and `shamt_err` at their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only by the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Dividend and shift count are valid this cycle |
| dividend | input | DW (32) | Two's-complement dividend |
| shamt | input | SW (5) | Power of two to divide by |
| out_valid | output | 1 | Quotient is valid |
| quotient | output | DW (32) | Signed quotient, truncated toward zero |
| shamt_err | output | 1 | Shift count was out of range |

## Verification
The range check and the quotient path resolve in the same output cycle. An illegal count must therefore win over whatever the shifter produced: the error flag rises and the quotient becomes zero. The sweep provokes this by applying the count 31 to every dividend in the set, including the most negative value and -1. It judges the error flag and the zeroed quotient together, on the cycle that `out_valid` rises. A second same-cycle pairing is the sign handling and the shift in the negative path. Each negative vector's quotient is compared against a truncating division computed at 64 bits in the bench, on both the registered magnitude build and the combinational bias build.

// File: rtl/pow2_sdiv_pkg.sv
package pow2_sdiv_pkg;

  // Selects which datapath computes the truncated quotient.
  typedef enum logic {
    FORM_MAG  = 1'b0,  // abs, shift, restore sign
    FORM_BIAS = 1'b1   // add (2^k-1) when negative, arithmetic shift
  } div_form_e;

  localparam int unsigned DEF_DW = 32;

endpackage

// File: rtl/sdiv_shamt_guard.sv
module sdiv_shamt_guard #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = $clog2(DW)
) (
  input  logic [SW-1:0] shamt,
  output logic          legal
);
  // The largest count that keeps at least the sign bit in range.
  localparam logic [SW-1:0] MAX_K = SW'(DW - 2);

  assign legal = (shamt <= MAX_K);
endmodule

// File: rtl/sdiv_mag_core.sv
module sdiv_mag_core #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] dividend,
  input  logic [SW-1:0] shamt,
  output logic [DW-1:0] q
);
  logic          neg;
  logic [DW-1:0] mag;
  logic [DW-1:0] shifted;

  assign neg = dividend[DW-1];

  // The most negative value maps to itself here. Treated as unsigned it is
  // exactly 2^(DW-1), so the logical shift below still gives the right size.
  assign mag     = neg ? (~dividend + 1'b1) : dividend;
  assign shifted = mag >> shamt;
  assign q       = neg ? (~shifted + 1'b1) : shifted;
endmodule

// File: rtl/sdiv_bias_core.sv
module sdiv_bias_core #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] dividend,
  input  logic [SW-1:0] shamt,
  output logic [DW-1:0] q
);
  logic [DW-1:0] low_mask;
  logic [DW-1:0] bias;
  logic [DW-1:0] biased;

  assign low_mask = ~({DW{1'b1}} << shamt);
  assign bias     = {DW{dividend[DW-1]}} & low_mask;
  // A negative dividend plus a bias below 2^(DW-1) cannot overflow.
  assign biased   = dividend + bias;
  assign q        = DW'($signed(biased) >>> shamt);
endmodule

// File: rtl/sdiv_out_stage.sv
module sdiv_out_stage #(
  parameter int unsigned DW      = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] q_in,
  input  logic          err_in,
  output logic          out_valid,
  output logic [DW-1:0] q_out,
  output logic          err_out
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          q_out     <= '0;
          err_out   <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            q_out   <= q_in;
            err_out <= err_in;
          end
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign q_out     = q_in;
      assign err_out   = err_in;
    end
  endgenerate
endmodule

// File: rtl/pow2_sdiv.sv
module pow2_sdiv
  import pow2_sdiv_pkg::*;
#(
  parameter int unsigned DW      = DEF_DW,
  parameter int unsigned SW      = $clog2(DW),
  parameter div_form_e   FORM    = FORM_MAG,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] dividend,
  input  logic [SW-1:0] shamt,
  output logic          out_valid,
  output logic [DW-1:0] quotient,
  output logic          shamt_err
);
  logic          k_legal;
  logic [DW-1:0] q_core;
  logic [DW-1:0] q_gated;

  sdiv_shamt_guard #(.DW(DW), .SW(SW)) u_guard (
    .shamt (shamt),
    .legal (k_legal)
  );

  generate
    if (FORM == FORM_MAG) begin : g_mag
      sdiv_mag_core #(.DW(DW), .SW(SW)) u_core (
        .dividend (dividend),
        .shamt    (shamt),
        .q        (q_core)
      );
    end else begin : g_bias
      sdiv_bias_core #(.DW(DW), .SW(SW)) u_core (
        .dividend (dividend),
        .shamt    (shamt),
        .q        (q_core)
      );
    end
  endgenerate

  assign q_gated = k_legal ? q_core : '0;

  sdiv_out_stage #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .q_in      (q_gated),
    .err_in    (~k_legal),
    .out_valid (out_valid),
    .q_out     (quotient),
    .err_out   (shamt_err)
  );
endmodule

// File: rtl/pow2_sdiv_chk.sv
module pow2_sdiv_chk #(
  parameter int unsigned DW      = 32,
  parameter int unsigned SW      = 5,
  parameter bit          REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [DW-1:0] dividend,
  input logic [SW-1:0] shamt,
  input logic          out_valid,
  input logic [DW-1:0] quotient,
  input logic          shamt_err
);
  localparam logic [SW-1:0] MAX_K = SW'(DW - 2);

  // R4
  err_forces_zero_chk: assert property (@(posedge clk) disable iff (rst)
    shamt_err |-> (quotient == '0));

  generate
    if (REG_OUT) begin : g_seq
      // R6
      valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

      // R4
      err_track_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid)) |-> (shamt_err == ($past(shamt) > MAX_K)));

      // R2
      sign_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !shamt_err && (quotient != '0))
          |-> (quotient[DW-1] == $past(dividend[DW-1])));

      // R9
      zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && ($past(shamt) == '0))
          |-> (quotient == $past(dividend)));

      // R10
      hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(quotient) && $stable(shamt_err)));
    end else begin : g_comb
      // R6
      valid_pass_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == in_valid);

      // R4
      err_track_chk: assert property (@(posedge clk) disable iff (rst)
        shamt_err == (shamt > MAX_K));

      // R2
      sign_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!shamt_err && (quotient != '0)) |-> (quotient[DW-1] == dividend[DW-1]));

      // R9
      zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (shamt == '0) |-> (quotient == dividend));
    end
  endgenerate
endmodule

bind pow2_sdiv pow2_sdiv_chk #(.DW(DW), .SW(SW), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .dividend  (dividend),
  .shamt     (shamt),
  .out_valid (out_valid),
  .quotient  (quotient),
  .shamt_err (shamt_err)
);

// File: tb/tb_pow2_sdiv.sv
module tb_pow2_sdiv;
  import pow2_sdiv_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] dividend;
  logic [4:0]  shamt;
  logic        ov_a, err_a, ov_b, err_b;
  logic [31:0] q_a, q_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Registered magnitude form
  pow2_sdiv #(.FORM(FORM_MAG), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dividend(dividend), .shamt(shamt),
    .out_valid(ov_a), .quotient(q_a), .shamt_err(err_a)
  );

  // Combinational bias form
  pow2_sdiv #(.FORM(FORM_BIAS), .REG_OUT(1'b0)) dut_b (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dividend(dividend), .shamt(shamt),
    .out_valid(ov_b), .quotient(q_b), .shamt_err(err_b)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_q(input logic [31:0] x, input int k);
    longint xl;
    longint d;
    if (k >= 31) return 32'd0;
    xl = longint'($signed(x));
    d  = 64'sd1 <<< k;
    return 32'(xl / d);
  endfunction

  function automatic string tag_of(input logic [31:0] x, input int k);
    if (k >= 31) return "R4";
    if (x == 32'h8000_0000) return "R3";
    if (k == 0) return "R9";
    if (x[31]) return "R2";
    return "R1";
  endfunction

  // Entered just after a falling edge; returns just after the next one.
  task automatic run_vec(input logic [31:0] x, input int k);
    logic [31:0] exp_q;
    logic        exp_e;
    string       t;
    exp_q = ref_q(x, k);
    exp_e = (k >= 31);
    t     = tag_of(x, k);
    in_valid = 1'b1;
    dividend = x;
    shamt    = 5'(k);
    #1;
    check({"R8 bias ", t}, q_b, exp_q);
    check(exp_e ? "R4 bias err" : "R5 bias err", {31'd0, err_b}, {31'd0, exp_e});
    @(negedge clk);
    check({"R6 reg ", t}, q_a, exp_q);
    check(exp_e ? "R4 reg err" : "R5 reg err", {31'd0, err_a}, {31'd0, exp_e});
    check("R6 out_valid", {31'd0, ov_a}, 32'd1);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    logic [31:0] lcg;
    logic [31:0] edges [12];
    edges = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
              32'h8000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFF8,
              32'h0000_0007, 32'hC000_0000, 32'h4000_0000, 32'hFFFF_0001};
    rst = 1'b1; in_valid = 1'b0; dividend = 32'h1234_5678; shamt = 5'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    check("R7 out_valid", {31'd0, ov_a}, 32'd0);
    check("R7 quotient", q_a, 32'd0);
    check("R7 err", {31'd0, err_a}, 32'd0);
    rst = 1'b0;

    for (int k = 0; k < 32; k++) begin
      for (int i = 0; i < 12; i++) run_vec(edges[i], k);
    end
    lcg = 32'h2545_F491;
    for (int k = 0; k < 32; k++) begin
      for (int i = 0; i < 24; i++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        run_vec(lcg, k);
      end
    end

    // R2 truncation toward zero, explicit
    run_vec(32'hFFFF_FFF9, 2);
    check("R2 -7/4", q_a, 32'hFFFF_FFFF);
    // R10 idle cycle keeps outputs
    in_valid = 1'b0; dividend = 32'd123; shamt = 5'd31;
    #1;
    check("R6 comb valid low", {31'd0, ov_b}, 32'd0);
    @(negedge clk);
    check("R10 hold quotient", q_a, 32'hFFFF_FFFF);
    check("R10 hold err", {31'd0, err_a}, 32'd0);
    check("R6 valid low", {31'd0, ov_a}, 32'd0);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end
endmodule